// File: doc/BRIEF.md
# Target Bus Event Interrupt Flags

This block keeps eight sticky interrupt flags for the target side of an I3C/I2C bus interface. The bus engine produces one-cycle event pulses: start, stop, restart, ACK received, static address hit, dynamic address hit, byte done and supported CCC. Before a pulse can set its flag, the block checks it against the current operating mode and the kind of transaction in progress. A flag that has been set holds its value until software writes it back to zero.

Software reaches two 8-bit registers through a simple strobe port. One holds the flags. The other holds a matching set of enables. A registered interrupt line is raised whenever any enabled flag is set. If a software write and a hardware set land in the same cycle, the written value is the one stored.

Top module: `tbe_event_flags`

## Requirements
- R1: While `rst` is high, and after it falls until the first event or write, the flag register, the enable register, `reg_rdata` and `irq` are all zero.
- R2: Flag and `ev_pulse` bit positions are: 7 start, 6 stop, 5 restart, 4 ACK received, 3 static address match, 2 dynamic address match, 1 byte done, 0 supported CCC. A qualified pulse sets its flag at the next clock edge. The byte-done event has no qualification.
- R3: A set flag stays at 1 until software writes it to 0. Further events on a set flag leave it at 1.
- R4: A write with `reg_wr` stores all 8 bits of `reg_wdata` into the register at `reg_addr`: 0 is the flags and 1 is the enables. Other addresses are ignored and read as 0. A read with `reg_rd` returns the register in `reg_rdata` one cycle later and changes nothing.
- R5: When a flag write and an event arrive in the same cycle, the flag register takes exactly the written data.
- R6: Start, stop and restart events are dropped while `op_mode[1]` is 1. `op_mode` encodes 00 for SDR, 01 for legacy I2C, and 1x for HDR.
- R7: The ACK event sets its flag only when `op_mode` is 01. In every other mode it is dropped.
- R8: The static match event counts only when `txn_kind` is 01 (private) or 10 (legacy I2C). The dynamic match event counts only when `txn_kind` is 01. `txn_kind` encodes 00 for idle and 11 for a broadcast command.
- R9: The CCC event always sets its flag when `ccc_direct` is 0. When `ccc_direct` is 1, it sets the flag only if `ccc_addressed` is 1.
- R10: `irq` is the registered OR over all bits of flags AND enables. It follows a change of either register by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 2 | Operating mode: 00 SDR, 01 legacy I2C, 1x HDR |
| txn_kind | input | 2 | Transaction kind: 00 idle, 01 private, 10 legacy I2C, 11 broadcast |
| ev_pulse | input | 8 | One-cycle event pulses, one bit per flag |
| ccc_direct | input | 1 | The current CCC is a direct command |
| ccc_addressed | input | 1 | The direct CCC targets this device |
| reg_addr | input | ADDR_W | Register select: 0 flags, 1 enables |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with its default parameters: a 2-bit address with the flags at 0 and the enables at 1. Eight flags with 2-bit mode and transaction fields make the qualification space small enough to sweep completely. Every event bit is applied under every mode, every transaction kind and all four CCC direct/addressed combinations, and each result is compared against a rule computed in the bench. On each bit, a same-cycle write races the event with both polarities of data. All 256 enable values are checked against the interrupt line.

// File: rtl/tbe_pkg.sv
package tbe_pkg;
  localparam int FLAG_W = 8;

  localparam int BIT_START   = 7;
  localparam int BIT_STOP    = 6;
  localparam int BIT_RESTART = 5;
  localparam int BIT_ACK     = 4;
  localparam int BIT_SMATCH  = 3;
  localparam int BIT_DMATCH  = 2;
  localparam int BIT_BYTE    = 1;
  localparam int BIT_CCC     = 0;

  typedef enum logic [1:0] {
    MODE_SDR  = 2'b00,
    MODE_I2C  = 2'b01,
    MODE_HDRA = 2'b10,
    MODE_HDRB = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    TXN_IDLE    = 2'b00,
    TXN_PRIVATE = 2'b01,
    TXN_LEGACY  = 2'b10,
    TXN_BCAST   = 2'b11
  } txn_kind_e;
endpackage

// File: rtl/tbe_qualify.sv
module tbe_qualify
  import tbe_pkg::*;
(
  input  logic [1:0]        op_mode,
  input  logic [1:0]        txn_kind,
  input  logic [FLAG_W-1:0] ev_pulse,
  input  logic              ccc_direct,
  input  logic              ccc_addressed,
  output logic [FLAG_W-1:0] set_vec
);
  logic bus_cond_ok;
  logic ack_ok;
  logic smatch_ok;
  logic dmatch_ok;
  logic ccc_ok;
  logic [FLAG_W-1:0] gate;

  always_comb begin
    bus_cond_ok = !op_mode[1];
    ack_ok      = (op_mode == MODE_I2C);
    smatch_ok   = (txn_kind == TXN_PRIVATE) || (txn_kind == TXN_LEGACY);
    dmatch_ok   = (txn_kind == TXN_PRIVATE);
    ccc_ok      = !ccc_direct || ccc_addressed;

    gate              = '0;
    gate[BIT_START]   = bus_cond_ok;
    gate[BIT_STOP]    = bus_cond_ok;
    gate[BIT_RESTART] = bus_cond_ok;
    gate[BIT_ACK]     = ack_ok;
    gate[BIT_SMATCH]  = smatch_ok;
    gate[BIT_DMATCH]  = dmatch_ok;
    gate[BIT_BYTE]    = 1'b1;
    gate[BIT_CCC]     = ccc_ok;

    set_vec = ev_pulse & gate;
  end
endmodule

// File: rtl/tbe_sticky_bank.sv
module tbe_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (we)       q[i] <= wdata[i];
      else if (set_vec[i]) q[i] <= 1'b1;
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !we) |=> q[i]);
  end

  // R5
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata)));
endmodule

// File: rtl/tbe_irq_gen.sv
module tbe_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] ena,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & ena);
  end
endmodule

// File: rtl/tbe_event_flags.sv
module tbe_event_flags
  import tbe_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int FLAG_ADDR = 0,
  parameter int ENA_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_mode,
  input  logic [1:0]        txn_kind,
  input  logic [7:0]        ev_pulse,
  input  logic              ccc_direct,
  input  logic              ccc_addressed,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] FLAG_SEL = FLAG_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] ENA_SEL  = ENA_ADDR[ADDR_W-1:0];

  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] ena;
  logic              flag_we;
  logic              ena_we;

  assign flag_we = reg_wr && (reg_addr == FLAG_SEL);
  assign ena_we  = reg_wr && (reg_addr == ENA_SEL);

  tbe_qualify u_qual (
    .op_mode       (op_mode),
    .txn_kind      (txn_kind),
    .ev_pulse      (ev_pulse),
    .ccc_direct    (ccc_direct),
    .ccc_addressed (ccc_addressed),
    .set_vec       (set_vec)
  );

  tbe_sticky_bank #(.W(FLAG_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .we      (flag_we),
    .wdata   (reg_wdata),
    .q       (flags)
  );

  tbe_sticky_bank #(.W(FLAG_W)) u_ena (
    .clk     (clk),
    .rst     (rst),
    .set_vec ('0),
    .we      (ena_we),
    .wdata   (reg_wdata),
    .q       (ena)
  );

  tbe_irq_gen #(.W(FLAG_W)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .flags (flags),
    .ena   (ena),
    .irq   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_addr == FLAG_SEL)     reg_rdata <= flags;
      else if (reg_addr == ENA_SEL) reg_rdata <= ena;
      else                          reg_rdata <= '0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags == '0 && ena == '0 && irq == 1'b0 && reg_rdata == '0));

  // R6
  hdr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op_mode[1] && !flag_we && flags[BIT_START:BIT_RESTART] == 3'b000)
      |=> flags[BIT_START:BIT_RESTART] == 3'b000);

  // R7
  ack_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (op_mode != MODE_I2C && !flag_we && !flags[BIT_ACK]) |=> !flags[BIT_ACK]);

  // R8
  dmatch_txn_chk: assert property (@(posedge clk) disable iff (rst)
    (txn_kind != TXN_PRIVATE && !flag_we && !flags[BIT_DMATCH]) |=> !flags[BIT_DMATCH]);

  // R9
  ccc_target_chk: assert property (@(posedge clk) disable iff (rst)
    (ccc_direct && !ccc_addressed && !flag_we && !flags[BIT_CCC]) |=> !flags[BIT_CCC]);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(flags & ena)));
endmodule

// File: tb/tbe_event_flags_tb.sv
`timescale 1ns/1ps
module tbe_event_flags_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op_mode = 2'b00;
  logic [1:0] txn_kind = 2'b00;
  logic [7:0] ev_pulse = 8'h00;
  logic       ccc_direct = 1'b0;
  logic       ccc_addressed = 1'b0;
  logic [1:0] reg_addr = 2'b00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  tbe_event_flags u_dut (
    .clk           (clk),
    .rst           (rst),
    .op_mode       (op_mode),
    .txn_kind      (txn_kind),
    .ev_pulse      (ev_pulse),
    .ccc_direct    (ccc_direct),
    .ccc_addressed (ccc_addressed),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rd        (reg_rd),
    .reg_rdata     (reg_rdata),
    .irq           (irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d, input logic [7:0] ev);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; ev_pulse = ev;
    @(negedge clk);
    reg_wr = 1'b0; ev_pulse = 8'h00;
  endtask

  task automatic do_pulse(input logic [7:0] ev);
    @(negedge clk);
    ev_pulse = ev;
    @(negedge clk);
    ev_pulse = 8'h00;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic exp_bit(input int b, input logic [1:0] m, input logic [1:0] t,
                                   input logic dir, input logic me);
    case (b)
      7, 6, 5: return !m[1];
      4:       return m == 2'b01;
      3:       return (t == 2'b01) || (t == 2'b10);
      2:       return t == 2'b01;
      1:       return 1'b1;
      default: return !dir || me;
    endcase
  endfunction

  function automatic string tag_of(input int b);
    case (b)
      7, 6, 5: return "R6";
      4:       return "R7";
      3, 2:    return "R8";
      1:       return "R2";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] rd2;
    logic [7:0] flagv;

    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 rdata in reset", reg_rdata, 8'h00);
    check("R1 irq in reset", {7'b0, irq}, 8'h00);
    rst = 1'b0;
    do_read(2'd0, rd); check("R1 flags after reset", rd, 8'h00);
    do_read(2'd1, rd); check("R1 enables after reset", rd, 8'h00);
    check("R1 irq after reset", {7'b0, irq}, 8'h00);

    // R2: layout, all events in a fully qualifying context
    op_mode = 2'b01; txn_kind = 2'b01; ccc_direct = 1'b0;
    do_pulse(8'hFF);
    do_read(2'd0, rd); check("R2 all events", rd, 8'hFF);

    // R3: sticky, repeated event keeps 1, read twice unchanged (R4)
    do_write(2'd0, 8'h00, 8'h00);
    do_pulse(8'h02);
    do_pulse(8'h02);
    do_read(2'd0, rd);  check("R3 sticky byte flag", rd, 8'h02);
    do_read(2'd0, rd2); check("R4 read no side effect", rd2, 8'h02);
    do_write(2'd0, 8'h00, 8'h00);
    do_read(2'd0, rd); check("R3 software clear", rd, 8'h00);

    // R4: full-width writes, unmapped address
    do_write(2'd0, 8'h3C, 8'h00);
    do_read(2'd0, rd); check("R4 flag write", rd, 8'h3C);
    do_write(2'd2, 8'hFF, 8'h00);
    do_read(2'd0, rd); check("R4 unmapped write ignored", rd, 8'h3C);
    do_read(2'd2, rd); check("R4 unmapped read", rd, 8'h00);
    do_write(2'd0, 8'h00, 8'h00);

    // R6 R7 R8 R9 R2: exhaustive qualification sweep
    for (int b = 0; b < 8; b++) begin
      for (int m = 0; m < 4; m++) begin
        for (int t = 0; t < 4; t++) begin
          for (int c = 0; c < 4; c++) begin
            op_mode = m[1:0]; txn_kind = t[1:0];
            ccc_direct = c[1]; ccc_addressed = c[0];
            do_pulse(8'(1 << b));
            do_read(2'd0, rd);
            check(tag_of(b), rd,
                  exp_bit(b, m[1:0], t[1:0], c[1], c[0]) ? 8'(1 << b) : 8'h00);
            do_write(2'd0, 8'h00, 8'h00);
          end
        end
      end
    end

    // R5: write versus event race on every bit, both data polarities
    op_mode = 2'b01; txn_kind = 2'b01; ccc_direct = 1'b0;
    for (int b = 0; b < 8; b++) begin
      do_write(2'd0, 8'h00, 8'(1 << b));
      do_read(2'd0, rd); check("R5 race write zero", rd, 8'h00);
      do_write(2'd0, ~8'(1 << b), 8'(1 << b));
      do_read(2'd0, rd); check("R5 race write other bits", rd, ~8'(1 << b));
      do_write(2'd0, 8'h00, 8'h00);
    end

    // R10: interrupt over every enable value
    for (int f = 0; f < 2; f++) begin
      flagv = (f == 0) ? 8'h96 : 8'h41;
      do_write(2'd0, flagv, 8'h00);
      for (int e = 0; e < 256; e++) begin
        do_write(2'd1, e[7:0], 8'h00);
        @(negedge clk);
        check("R10 irq", {7'b0, irq}, {7'b0, |(flagv & e[7:0])});
      end
    end
    do_read(2'd1, rd); check("R4 enable readback", rd, 8'hFF);
    do_write(2'd0, 8'h00, 8'h00);
    @(negedge clk);
    check("R10 irq after clear", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule